// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking page tables held in memory. A request carries the virtual address, a context number, a write flag and a fetch flag. The walker reads one 32-bit word at a time over a request/ready memory port. It starts from the slot for that context in a root table, then follows pointer entries down through up to three levels of directory. The walk ends at a leaf entry or at a fault.

On success the walker returns four things: the physical address, an encoded page size, the leaf entry as updated, and a write-allowed flag. When the referenced or modified bit of the leaf has to change, the walker writes the entry back to memory before it signals completion. On failure it returns a ten-bit fault code that holds the level where the walk stopped and the kind of failure.

A bypass input skips translation altogether. When a boot input is also set, instruction fetches are redirected to a boot-ROM window. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a walk goes to the address cfg_root shifted left by 4 plus req_ctx shifted left by 2.
- R2: The two low bits of each fetched entry give its type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer read at level n (n = 0, 1, 2) makes the next read go to the pointer with bits [1:0] cleared, shifted left by 4, plus an index times 4. The index is VA[31:24] for level 1, VA[23:18] for level 2 and VA[17:12] for level 3. A walk makes at most four reads.
- R3: A leaf at level 1 maps a 16 MB page (rsp_size 2), a leaf at level 2 a 256 KB page (rsp_size 1), and a leaf at level 3 a 4 KB page (rsp_size 0). rsp_pa is entry[31:8] shifted left by 12, plus the VA bits below the page size.
- R4: A fault sets rsp_fault and gives rsp_fcode = level in bits [9:8] and type in bits [4:2], with all other bits zero. An invalid entry gives type 1. A reserved entry, a leaf found in the context table (level 0), or a pointer found at level 3 gives type 4. rsp_pa is 0 on a fault.
- R5: A memory error on a read gives fault type 4 at the level of that read.
- R6: On success the leaf is returned with bit 5 (referenced) set. On a write, bit 6 (modified) is also set. The updated entry is written back to the leaf's address only when its value changed, and it is never written back after a fault.
- R7: On a walked translation, rsp_wr_ok equals bit 6 of the returned (updated) leaf entry.
- R8: In bypass mode without the boot condition, rsp_pa equals the virtual address, rsp_wr_ok is 1, and no memory access is made.
- R9: In bypass mode with boot set, a fetch gets rsp_pa = cfg_prom OR VA[18:0] and rsp_wr_ok = 0. A non-fetch access in that mode still gets rsp_pa equal to the VA.
- R10: busy is high from the cycle after a request is accepted until the walk ends. done pulses for one cycle with the results, and the results hold until the next accepted request. req_valid is ignored while busy.
- R11: mem_req, mem_we and mem_addr hold steady until mem_ready is seen.
- R12: Reset clears busy, done and mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a translation (taken when busy is low) |
| req_va | input | 32 | Virtual address |
| req_ctx | input | CTX_W | Context number |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| cfg_bypass | input | 1 | Physical bypass mode |
| cfg_boot | input | 1 | Boot mode (fetches go to the ROM window) |
| cfg_root | input | 32 | Context-table pointer |
| cfg_prom | input | PA_W | Boot ROM base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Walk failed |
| rsp_fcode | output | 10 | Fault level and type |
| rsp_pa | output | PA_W | Physical address |
| rsp_size | output | 2 | Page size code |
| rsp_pte | output | 32 | Updated leaf entry |
| rsp_wr_ok | output | 1 | Write permitted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | PA_W | Word address in bytes |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_err | input | 1 | Bus error, valid with mem_ready |

## Verification
Errors in the walk level or the held address show up at the memory port first. The read following a bad pointer goes to a wrong address in the very next access, and the bench records the address of every read. A wrong level counter also shows in the level field of the fault code, or in a wrong page size and offset once done pulses. Corrupted update logic shows as a missing or extra write-back, or as wrong data in it, before done rises. The handshake is exercised with stalled memory responses and with requests arriving during a walk.

// File: rtl/ptw_pkg.sv
// Shared types and helpers for the page table walker.
// Assumes a 32-bit virtual address and 32-bit table entries.
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int ENT_W     = 32;
    localparam int FCODE_W   = 10;
    localparam int REF_BIT   = 5;
    localparam int MOD_BIT   = 6;
    localparam int MAX_READS = 4;

    typedef enum logic [1:0] {
        ET_INVALID  = 2'd0,
        ET_POINTER  = 2'd1,
        ET_LEAF     = 2'd2,
        ET_RESERVED = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        WK_DESCEND = 2'd0,
        WK_LEAF    = 2'd1,
        WK_FAULT   = 2'd2
    } walk_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    localparam logic [1:0] PG_4K   = 2'd0;
    localparam logic [1:0] PG_256K = 2'd1;
    localparam logic [1:0] PG_16M  = 2'd2;

    localparam logic [2:0] FT_NONE    = 3'd0;
    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLATE   = 3'd4;

    // Pack a level and a fault type into the reported code.
    function automatic logic [FCODE_W-1:0] mk_fcode(input logic [1:0] lvl,
                                                    input logic [2:0] ftype);
        return {lvl, 3'b000, ftype, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
// Address generator: computes the context-table slot address and the
// next-level read address from a pointer entry and the virtual address.
// Assumes PA_W is at least 36 so a shifted 32-bit pointer fits.
module ptw_addr_gen #(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic [31:0]      root,
    input  logic [CTX_W-1:0] ctx,
    input  logic [29:0]      ptr,       // pointer entry bits [31:2]
    input  logic [19:0]      va_hi,     // virtual address bits [31:12]
    input  logic [1:0]       nxt_lvl,   // level of the table being indexed
    output logic [PA_W-1:0]  root_addr,
    output logic [PA_W-1:0]  next_addr
);
    localparam int IDX_W = 10;

    logic [PA_W-1:0]  tbl_base;
    logic [IDX_W-1:0] idx_off;

    // Root slot: table pointer scaled by 16 plus context scaled by 4.
    always_comb begin
        root_addr = (PA_W'(root) << 4) + PA_W'({ctx, 2'b00});
    end

    // Next read: cleared pointer scaled by 16 plus the level's index.
    always_comb begin
        tbl_base = PA_W'({ptr, 2'b00}) << 4;
        case (nxt_lvl)
            2'd1:    idx_off = {va_hi[19:12], 2'b00};
            2'd2:    idx_off = {2'b00, va_hi[11:6], 2'b00};
            default: idx_off = {2'b00, va_hi[5:0], 2'b00};
        endcase
        next_addr = tbl_base + PA_W'(idx_off);
    end
endmodule

// File: rtl/ptw_entry_dec.sv
// Entry decoder: classifies a fetched entry at a given level as descend,
// leaf or fault, and forms the updated leaf with its usage bits.
// Assumes level 0 is the context table and level 3 is the last level.
module ptw_entry_dec
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [1:0]       lvl,
    input  logic             is_write,
    output walk_kind_e       kind,
    output logic [2:0]       ftype,
    output logic [ENT_W-1:0] upd_entry,
    output logic             need_wb
);
    ent_type_e etype;

    // Classify the entry by its type field and the level it came from.
    always_comb begin
        etype = ent_type_e'(entry[1:0]);
        kind  = WK_FAULT;
        ftype = FT_XLATE;
        case (etype)
            ET_INVALID: begin
                kind  = WK_FAULT;
                ftype = FT_INVALID;
            end
            ET_POINTER: begin
                if (lvl != 2'd3) begin
                    kind  = WK_DESCEND;
                    ftype = FT_NONE;
                end
            end
            ET_LEAF: begin
                if (lvl != 2'd0) begin
                    kind  = WK_LEAF;
                    ftype = FT_NONE;
                end
            end
            default: begin
                kind  = WK_FAULT;
                ftype = FT_XLATE;
            end
        endcase
    end

    // Set referenced always and modified on writes; flag a changed value.
    always_comb begin
        upd_entry          = entry;
        upd_entry[REF_BIT] = 1'b1;
        if (is_write) upd_entry[MOD_BIT] = 1'b1;
        need_wb = (upd_entry != entry);
    end
endmodule

// File: rtl/ptw_leaf_fmt.sv
// Leaf formatter: forms the physical address and page size code from a
// leaf entry and the level it was found at (1, 2 or 3).
module ptw_leaf_fmt
    import ptw_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [23:0]     ppn,      // leaf entry bits [31:8]
    input  logic [1:0]      lvl,
    input  logic [23:0]     va_lo,    // virtual address bits [23:0]
    output logic [PA_W-1:0] pa,
    output logic [1:0]      size
);
    logic [PA_W-1:0] page_base;
    logic [23:0]     pg_off;

    // Select the offset width by level and add it to the page base.
    always_comb begin
        page_base = PA_W'(ppn) << 12;
        case (lvl)
            2'd1: begin
                pg_off = va_lo;
                size   = PG_16M;
            end
            2'd2: begin
                pg_off = {6'd0, va_lo[17:0]};
                size   = PG_256K;
            end
            default: begin
                pg_off = {12'd0, va_lo[11:0]};
                size   = PG_4K;
            end
        endcase
        pa = page_base + PA_W'(pg_off);
    end
endmodule

// File: rtl/ptw_walker.sv
// Page table walker top: accepts one request at a time, walks the context
// table and up to three directory levels over a request/ready port,
// writes back usage bits, and reports the result with a done pulse.
// Assumes memory holds mem_rdata/mem_err valid in the mem_ready cycle.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8,
    parameter int PA_W  = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [31:0]        req_va,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic               req_write,
    input  logic               req_fetch,
    input  logic               cfg_bypass,
    input  logic               cfg_boot,
    input  logic [31:0]        cfg_root,
    input  logic [PA_W-1:0]    cfg_prom,
    output logic               busy,
    output logic               done,
    output logic               rsp_fault,
    output logic [9:0]         rsp_fcode,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [1:0]         rsp_size,
    output logic [31:0]        rsp_pte,
    output logic               rsp_wr_ok,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_W-1:0]    mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ready,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_err
);
    localparam int BOOT_W = 19;
    localparam int CNT_W  = $clog2(MAX_READS + 1);

    walk_state_e      state;
    logic [1:0]       lvl;
    logic [PA_W-1:0]  cur_addr;
    logic [31:0]      va_q;
    logic             wr_q;
    logic [CNT_W-1:0] rd_cnt;

    logic [PA_W-1:0]  root_addr;
    logic [PA_W-1:0]  next_addr;
    walk_kind_e       kind;
    logic [2:0]       ftype;
    logic [31:0]      upd_entry;
    logic             need_wb;
    logic [PA_W-1:0]  leaf_pa;
    logic [1:0]       leaf_size;
    logic             accept;

    ptw_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
        .root      (cfg_root),
        .ctx       (req_ctx),
        .ptr       (mem_rdata[31:2]),
        .va_hi     (va_q[31:12]),
        .nxt_lvl   (2'(lvl + 2'd1)),
        .root_addr (root_addr),
        .next_addr (next_addr)
    );

    ptw_entry_dec u_dec (
        .entry     (mem_rdata),
        .lvl       (lvl),
        .is_write  (wr_q),
        .kind      (kind),
        .ftype     (ftype),
        .upd_entry (upd_entry),
        .need_wb   (need_wb)
    );

    ptw_leaf_fmt #(.PA_W(PA_W)) u_leaf (
        .ppn   (mem_rdata[31:8]),
        .lvl   (lvl),
        .va_lo (va_q[23:0]),
        .pa    (leaf_pa),
        .size  (leaf_size)
    );

    // Port decode of the walk state.
    always_comb begin
        busy      = (state == ST_READ) || (state == ST_WBACK);
        done      = (state == ST_DONE);
        mem_req   = busy;
        mem_we    = (state == ST_WBACK);
        mem_addr  = cur_addr;
        mem_wdata = rsp_pte;
        accept    = req_valid && !busy;
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lvl       <= 2'd0;
            cur_addr  <= '0;
            va_q      <= '0;
            wr_q      <= 1'b0;
            rd_cnt    <= '0;
            rsp_fault <= 1'b0;
            rsp_fcode <= '0;
            rsp_pa    <= '0;
            rsp_size  <= PG_4K;
            rsp_pte   <= '0;
            rsp_wr_ok <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    state <= ST_IDLE;
                    if (accept) begin
                        va_q   <= req_va;
                        wr_q   <= req_write;
                        rd_cnt <= '0;
                        if (cfg_bypass) begin
                            rsp_fault <= 1'b0;
                            rsp_fcode <= '0;
                            rsp_size  <= PG_4K;
                            rsp_pte   <= '0;
                            if (cfg_boot && req_fetch) begin
                                rsp_pa    <= cfg_prom | PA_W'(req_va[BOOT_W-1:0]);
                                rsp_wr_ok <= 1'b0;
                            end else begin
                                rsp_pa    <= PA_W'(req_va);
                                rsp_wr_ok <= 1'b1;
                            end
                            state <= ST_DONE;
                        end else begin
                            lvl      <= 2'd0;
                            cur_addr <= root_addr;
                            state    <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        rd_cnt <= rd_cnt + 1'b1;
                        if (mem_err || kind == WK_FAULT) begin
                            rsp_fault <= 1'b1;
                            rsp_fcode <= mk_fcode(lvl, mem_err ? FT_XLATE : ftype);
                            rsp_pa    <= '0;
                            rsp_size  <= PG_4K;
                            rsp_pte   <= '0;
                            rsp_wr_ok <= 1'b0;
                            state     <= ST_DONE;
                        end else if (kind == WK_DESCEND) begin
                            lvl      <= lvl + 2'd1;
                            cur_addr <= next_addr;
                        end else begin
                            rsp_fault <= 1'b0;
                            rsp_fcode <= '0;
                            rsp_pa    <= leaf_pa;
                            rsp_size  <= leaf_size;
                            rsp_pte   <= upd_entry;
                            rsp_wr_ok <= upd_entry[MOD_BIT];
                            state     <= need_wb ? ST_WBACK : ST_DONE;
                        end
                    end
                end
                ST_WBACK: begin
                    if (mem_ready) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10
    accept_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R2
    walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) && mem_ready |-> rd_cnt < CNT_W'(MAX_READS));

    // R6
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[REF_BIT]);

    // R4
    fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && rsp_fault |-> rsp_pa == '0 && !rsp_wr_ok);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    localparam int PA_W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0] req_ctx = '0;
    logic req_write = 1'b0, req_fetch = 1'b0;
    logic cfg_bypass = 1'b0, cfg_boot = 1'b0;
    logic [31:0] cfg_root = 32'h10;
    logic [PA_W-1:0] cfg_prom = 36'hFF0000000;
    logic busy, done, rsp_fault, rsp_wr_ok;
    logic [9:0] rsp_fcode;
    logic [PA_W-1:0] rsp_pa;
    logic [1:0] rsp_size;
    logic [31:0] rsp_pte;
    logic mem_req, mem_we;
    logic [PA_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic mem_err = 1'b0;

    always #4 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ctx(req_ctx), .req_write(req_write), .req_fetch(req_fetch),
        .cfg_bypass(cfg_bypass), .cfg_boot(cfg_boot), .cfg_root(cfg_root),
        .cfg_prom(cfg_prom), .busy(busy), .done(done), .rsp_fault(rsp_fault),
        .rsp_fcode(rsp_fcode), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
        .rsp_pte(rsp_pte), .rsp_wr_ok(rsp_wr_ok), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    logic [31:0] mem_model [logic [35:0]];
    int n_cmp = 0, n_bad = 0;
    int lat = 0, wait_cnt = 0;
    int rd_walk = 0, wb_walk = 0;
    logic [35:0] rd_log [0:7];
    logic [35:0] wb_addr;
    logic [31:0] wb_data;
    bit err_on = 0;
    logic [35:0] err_addr = '0;

    // Memory responder with programmable latency.
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            mem_err = 1'b0;
            if (mem_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    mem_ready = 1'b1;
                    if (mem_we) begin
                        mem_model[mem_addr] = mem_wdata;
                        wb_addr = mem_addr;
                        wb_data = mem_wdata;
                        wb_walk++;
                    end else begin
                        if (rd_walk < 8) rd_log[rd_walk] = mem_addr;
                        rd_walk++;
                        mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
                        mem_err = err_on && (mem_addr == err_addr);
                    end
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] page_base(input logic [31:0] e);
        return {e[31:8], 12'h000};
    endfunction

    task automatic walk(input logic [31:0] va, input logic [7:0] ctx,
                        input bit wr, input bit fetch);
        @(negedge clk);
        rd_walk = 0;
        wb_walk = 0;
        req_va = va; req_ctx = ctx; req_write = wr; req_fetch = fetch;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R12 busy", 36'(busy), 36'd0);
        chk("R12 done", 36'(done), 36'd0);
        chk("R12 mem_req", 36'(mem_req), 36'd0);
    endtask

    task automatic t_small_read;
        walk(32'h12345678, 8'd1, 1'b0, 1'b0);
        chk("R1 first read", rd_log[0], 36'h104);
        chk("R2 l1 read", rd_log[1], 36'h1048);
        chk("R2 l2 read", rd_log[2], 36'h2034);
        chk("R2 l3 read", rd_log[3], 36'h3014);
        chk("R2 read count", 36'(rd_walk), 36'd4);
        chk("R3 4k pa", rsp_pa, page_base(32'h0ABCDE02) + 36'h678);
        chk("R3 4k size", 36'(rsp_size), 36'd0);
        chk("R6 pte", 36'(rsp_pte), 36'h0ABCDE22);
        chk("R6 wb count", 36'(wb_walk), 36'd1);
        chk("R6 wb addr", wb_addr, 36'h3014);
        chk("R6 wb data", 36'(wb_data), 36'h0ABCDE22);
        chk("R7 wr_ok clear", 36'(rsp_wr_ok), 36'd0);
        chk("R4 no fault", 36'(rsp_fault), 36'd0);
    endtask

    task automatic t_no_wb_then_write;
        walk(32'h12345678, 8'd1, 1'b0, 1'b0);
        chk("R6 no wb when unchanged", 36'(wb_walk), 36'd0);
        walk(32'h12345ABC, 8'd1, 1'b1, 1'b0);
        chk("R6 write wb count", 36'(wb_walk), 36'd1);
        chk("R6 write wb data", 36'(wb_data), 36'h0ABCDE62);
        chk("R7 wr_ok after write", 36'(rsp_wr_ok), 36'd1);
        chk("R3 4k pa write", rsp_pa, page_base(32'h0ABCDE62) + 36'hABC);
    endtask

    task automatic t_large_pages;
        walk(32'h12800123, 8'd1, 1'b0, 1'b0);
        chk("R3 256k pa", rsp_pa, page_base(32'h00555562) + 36'h00123);
        chk("R3 256k size", 36'(rsp_size), 36'd1);
        chk("R6 256k no wb", 36'(wb_walk), 36'd0);
        chk("R7 256k wr_ok", 36'(rsp_wr_ok), 36'd1);
        walk(32'h40ABCDEF, 8'd1, 1'b1, 1'b0);
        chk("R3 16m pa", rsp_pa, page_base(32'h07000062) + 36'hABCDEF);
        chk("R3 16m size", 36'(rsp_size), 36'd2);
        chk("R2 16m reads", 36'(rd_walk), 36'd2);
    endtask

    task automatic t_faults;
        walk(32'h50000000, 8'd1, 1'b0, 1'b0);
        chk("R4 invalid l1", 36'(rsp_fcode), 36'h104);
        chk("R4 fault flag", 36'(rsp_fault), 36'd1);
        chk("R4 fault pa", rsp_pa, 36'd0);
        walk(32'h12C00000, 8'd1, 1'b1, 1'b0);
        chk("R4 reserved l2", 36'(rsp_fcode), 36'h210);
        chk("R6 no wb on fault", 36'(wb_walk), 36'd0);
        walk(32'h00000000, 8'd2, 1'b0, 1'b0);
        chk("R4 leaf at ctx", 36'(rsp_fcode), 36'h010);
        walk(32'h12346000, 8'd1, 1'b0, 1'b0);
        chk("R4 pointer at l3", 36'(rsp_fcode), 36'h310);
        walk(32'h12345678, 8'd3, 1'b0, 1'b0);
        chk("R4 invalid ctx", 36'(rsp_fcode), 36'h004);
    endtask

    task automatic t_bus_error;
        err_on = 1; err_addr = 36'h2034;
        walk(32'h12345678, 8'd1, 1'b0, 1'b0);
        chk("R5 bus error l2", 36'(rsp_fcode), 36'h210);
        chk("R5 reads stop", 36'(rd_walk), 36'd3);
        err_on = 0;
    endtask

    task automatic t_bypass;
        cfg_bypass = 1'b1;
        walk(32'h89ABCDEF, 8'd1, 1'b1, 1'b0);
        chk("R8 pa", rsp_pa, 36'h089ABCDEF);
        chk("R8 wr_ok", 36'(rsp_wr_ok), 36'd1);
        chk("R8 no reads", 36'(rd_walk), 36'd0);
        cfg_boot = 1'b1;
        walk(32'h89ABCDEF, 8'd1, 1'b0, 1'b1);
        chk("R9 boot fetch pa", rsp_pa, 36'hFF0000000 | 36'(32'h89ABCDEF & 32'h7FFFF));
        chk("R9 boot fetch wr_ok", 36'(rsp_wr_ok), 36'd0);
        walk(32'h89ABCDEF, 8'd1, 1'b0, 1'b0);
        chk("R9 boot data pa", rsp_pa, 36'h089ABCDEF);
        cfg_boot = 1'b0; cfg_bypass = 1'b0;
    endtask

    task automatic t_busy_ignore;
        int extra;
        lat = 3;
        @(negedge clk);
        rd_walk = 0; wb_walk = 0;
        req_va = 32'h12345678; req_ctx = 8'd1; req_write = 1'b0; req_fetch = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", 36'(busy), 36'd1);
        @(negedge clk);
        req_va = 32'h40ABCDEF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R10 first result kept", rsp_pa, page_base(32'h0ABCDE22) + 36'h678);
        chk("R10 busy low at done", 36'(busy), 36'd0);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        chk("R10 ignored request", 36'(extra), 36'd0);
        chk("R10 result held", rsp_pa, page_base(32'h0ABCDE22) + 36'h678);
        lat = 1;
        walk(32'h12800123, 8'd1, 1'b0, 1'b0);
        chk("R11 stalled walk pa", rsp_pa, page_base(32'h00555562) + 36'h00123);
    endtask

    initial begin
        mem_model[36'h104]  = 32'h00000101;
        mem_model[36'h108]  = 32'h00000002;
        mem_model[36'h1048] = 32'h00000201;
        mem_model[36'h1100] = 32'h07000062;
        mem_model[36'h2034] = 32'h00000301;
        mem_model[36'h2080] = 32'h00555562;
        mem_model[36'h20C0] = 32'h00000003;
        mem_model[36'h3014] = 32'h0ABCDE02;
        mem_model[36'h3018] = 32'h00000301;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_read();
        t_no_wb_then_write();
        t_large_pages();
        t_faults();
        t_bus_error();
        t_bypass();
        t_busy_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule